// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one conversion of an on-chip successive-approximation ADC. Its timing comes from the ADC clock. When a start request arrives while the block is idle, it takes a snapshot of the sample-time control value and the resolution selection. It then runs three phases in order:

- an acquisition window whose length is set by the control value;
- a short hold phase;
- a bit-by-bit search, most significant bit first.

During the search it presents a trial code to the capacitor DAC and reads back a one-bit comparator decision. The analog parts sit outside the block and appear only as the `dacCode` output and the `cmpIn` input.

Two status outputs report progress. `busy` covers the whole conversion and `sampling` covers only the acquisition window. When the last bit is decided, the result register is loaded, `busy` falls and `done` pulses for one cycle.

A separate combinational path turns a required minimum acquisition time into the smallest control value that meets it. The time is given as a fixed-point count of clock periods, and any fraction is rounded up.

Top module: `sar_conv_sequencer`

## Requirements
- R1: While reset is held, and after it is released until a start arrives, `busy`, `sampling` and `done` are 0, and `result` and `dacCode` are all zeros.
- R2: A start request in a cycle where `busy` is 0 makes `busy` and `sampling` both go to 1 at the next rising clock edge.
- R3: `sampling` stays 1 for exactly 2 + STC clock cycles, where STC is the 8-bit `stcIn` value (0 to 255) captured with the start.
- R4: When `sampling` falls, `busy` stays 1 for HOLD_CYC hold cycles (default 1), plus one cycle per result bit, with `sampling` at 0 throughout.
- R5: `resSel` encodes the resolution as 0 = 8 bits, 1 = 10 bits, 2 or 3 = 12 bits. The result is right-justified with its upper bits zero. A comparator value of 1 means the input is at or above the trial code, and that trial bit is kept.
- R6: Bits are tried one per cycle, most significant first. The first trial code presented is 1 shifted left by (bits − 1), and `dacCode` is zero outside the search.
- R7: `done` is a one-cycle pulse. It occurs in the same cycle that `busy` falls and `result` takes the new value, and `result` holds that value until the next completion.
- R8: A start request while `busy` is 1 is ignored. It neither changes the running conversion's timing nor causes another conversion afterwards.
- R9: `stcIn` and `resSel` take effect only at start. Changing them during a conversion alters neither its timing nor its result.
- R10: `stcFit` = clamp(ceil(`minSampleQ` / 16) − 2, 0, 255). `minSampleQ` is an unsigned count of clock periods with 4 fractional bits. For example, 72, 88 and 104 give 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, taken only while idle |
| stcIn | input | 8 | Sample-time control value |
| resSel | input | 2 | Resolution select |
| cmpIn | input | 1 | Comparator decision for the current trial code |
| dacCode | output | 12 | Trial code during the search, else zero |
| busy | output | 1 | Conversion in progress |
| sampling | output | 1 | Acquisition window active |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Last conversion result, right-justified |
| minSampleQ | input | 16 | Required minimum sample time, in clock periods with 4 fractional bits |
| stcFit | output | 8 | Smallest control value meeting `minSampleQ` |

## Verification
The bench sweeps every STC value from 0 to 255, so an off-by-one in the window counter shows up as a window of 1 + STC or 3 + STC cycles. It converts every 8-bit code and strided sets of 10-bit and 12-bit codes, including full scale. A search that ran least significant bit first, or dropped the final decision, would return wrong codes at the extremes. After each start it changes the configuration inputs and sends a second start mid-conversion. A design that failed to capture the configuration would stretch the window or truncate the result, and one that accepted the late start would begin a second conversion. The sizing helper is checked over a range of inputs that crosses both clamps and every fractional boundary, which catches truncation in place of rounding up.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_HOLD,
    ST_CONV
  } seqState_t;

  typedef struct packed {
    logic latchCfg;
    logic loadHold;
    logic startConv;
    logic trialEn;
    logic finish;
  } seqStrobe_t;

  function automatic int unsigned resBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 10;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/sar_stc_fit.sv
module sar_stc_fit #(
  parameter int REQ_W    = 16,
  parameter int REQ_FRAC = 4,
  parameter int STC_W    = 8
) (
  input  logic [REQ_W-1:0] minSampleQ,
  output logic [STC_W-1:0] stcFit
);
  localparam int EXT_W    = REQ_W + 2;
  localparam int STC_MAX  = (1 << STC_W) - 1;
  localparam int FRAC_ONE = 1 << REQ_FRAC;

  logic [EXT_W-1:0] ceilVal;

  always_comb begin
    ceilVal = ({2'b00, minSampleQ} + EXT_W'(FRAC_ONE - 1)) >> REQ_FRAC;
    if (ceilVal <= EXT_W'(2))
      stcFit = '0;
    else if (ceilVal - EXT_W'(2) > EXT_W'(STC_MAX))
      stcFit = STC_W'(STC_MAX);
    else
      stcFit = STC_W'(ceilVal - EXT_W'(2));
  end

  // Between the clamps the window (stcFit + 2) periods must cover the request,
  // and one period less must not.
  always_comb begin
    if (!$isunknown(minSampleQ) && stcFit != '0 && stcFit != STC_W'(STC_MAX)) begin
      assert_fit_minimal_R10: assert (
        (({{(EXT_W-STC_W){1'b0}}, stcFit} + EXT_W'(2)) << REQ_FRAC) >= {2'b00, minSampleQ} &&
        (({{(EXT_W-STC_W){1'b0}}, stcFit} + EXT_W'(1)) << REQ_FRAC) <  {2'b00, minSampleQ})
        else $error("stcFit not minimal");
    end
  end
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int MAX_BITS = 12,
  parameter int STC_W    = 8,
  parameter int HOLD_CYC = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STC_W-1:0]    stcIn,
  input  logic [1:0]          resSel,
  input  logic                cmpIn,
  input  seqStrobe_t          strobe,
  output logic                cntZero,
  output logic                lastBit,
  output logic [MAX_BITS-1:0] dacCode,
  output logic [MAX_BITS-1:0] result
);
  localparam int CNT_W = STC_W + 1;
  localparam int IDX_W = $clog2(MAX_BITS);

  logic [CNT_W-1:0]    phaseCnt;
  logic [IDX_W-1:0]    topIdx;
  logic [IDX_W-1:0]    bitIdx;
  logic [MAX_BITS-1:0] sarReg;
  logic [MAX_BITS-1:0] resultQ;
  logic [MAX_BITS-1:0] trialCode;
  logic [MAX_BITS-1:0] nextSar;

  always_comb begin
    trialCode = sarReg | (MAX_BITS'(1) << bitIdx);
    nextSar   = cmpIn ? trialCode : sarReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      topIdx   <= '0;
    end else if (strobe.latchCfg) begin
      phaseCnt <= {1'b0, stcIn} + CNT_W'(1);
      topIdx   <= IDX_W'(resBits(resSel) - 1);
    end else if (strobe.loadHold) begin
      phaseCnt <= CNT_W'(HOLD_CYC - 1);
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx <= '0;
      sarReg <= '0;
    end else if (strobe.startConv) begin
      bitIdx <= topIdx;
      sarReg <= '0;
    end else if (strobe.trialEn) begin
      bitIdx <= bitIdx - IDX_W'(1);
      sarReg <= nextSar;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      resultQ <= '0;
    else if (strobe.finish)
      resultQ <= nextSar;
  end

  assign cntZero = (phaseCnt == '0);
  assign lastBit = (bitIdx == '0);
  assign dacCode = strobe.trialEn ? trialCode : '0;
  assign result  = resultQ;

  assert_first_trial_msb_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startConv |=> (dacCode == (MAX_BITS'(1) << topIdx)))
    else $error("first trial is not the top bit");

  assert_result_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(resultQ))
    else $error("result changed without completion");
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cntZero,
  input  logic       lastBit,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       sampling,
  output logic       done
);
  seqState_t state;
  seqState_t nextState;
  logic      doneQ;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (startReq) begin
        strobe.latchCfg = 1'b1;
        nextState       = ST_SAMPLE;
      end
      ST_SAMPLE: if (cntZero) begin
        strobe.loadHold = 1'b1;
        nextState       = ST_HOLD;
      end
      ST_HOLD: if (cntZero) begin
        strobe.startConv = 1'b1;
        nextState        = ST_CONV;
      end
      ST_CONV: begin
        strobe.trialEn = 1'b1;
        if (lastBit) begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= strobe.finish;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign sampling = (state == ST_SAMPLE);
  assign done     = doneQ;

  assert_busy_opens_with_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> sampling)
    else $error("busy rose without sampling");

  assert_busy_after_sample_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampling) |-> busy)
    else $error("busy dropped with sampling");

  assert_done_marks_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done)
    else $error("busy fell without done");

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("done longer than one cycle");

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> !$rose(sampling))
    else $error("start accepted while busy");
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
  import sar_seq_pkg::*;
#(
  parameter int MAX_BITS = 12,
  parameter int STC_W    = 8,
  parameter int HOLD_CYC = 1,
  parameter int REQ_W    = 16,
  parameter int REQ_FRAC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [STC_W-1:0]    stcIn,
  input  logic [1:0]          resSel,
  input  logic                cmpIn,
  output logic [MAX_BITS-1:0] dacCode,
  output logic                busy,
  output logic                sampling,
  output logic                done,
  output logic [MAX_BITS-1:0] result,
  input  logic [REQ_W-1:0]    minSampleQ,
  output logic [STC_W-1:0]    stcFit
);
  seqStrobe_t strobe;
  logic       cntZero;
  logic       lastBit;

  sar_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cntZero  (cntZero),
    .lastBit  (lastBit),
    .strobe   (strobe),
    .busy     (busy),
    .sampling (sampling),
    .done     (done)
  );

  sar_seq_dp #(
    .MAX_BITS (MAX_BITS),
    .STC_W    (STC_W),
    .HOLD_CYC (HOLD_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stcIn   (stcIn),
    .resSel  (resSel),
    .cmpIn   (cmpIn),
    .strobe  (strobe),
    .cntZero (cntZero),
    .lastBit (lastBit),
    .dacCode (dacCode),
    .result  (result)
  );

  sar_stc_fit #(
    .REQ_W    (REQ_W),
    .REQ_FRAC (REQ_FRAC),
    .STC_W    (STC_W)
  ) u_fit (
    .minSampleQ (minSampleQ),
    .stcFit     (stcFit)
  );
endmodule

// File: tb/sar_conv_sequencer_bench.sv
module sar_conv_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_CYC   = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  stcIn = '0;
  logic [1:0]  resSel = '0;
  logic        cmpIn;
  logic [11:0] dacCode;
  logic        busy, sampling, done;
  logic [11:0] result;
  logic [15:0] minSampleQ = '0;
  logic [7:0]  stcFit;

  int analogCode = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmpIn = (analogCode >= int'(dacCode));

  sar_conv_sequencer u_sar_conv_sequencer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stcIn(stcIn), .resSel(resSel),
    .cmpIn(cmpIn), .dacCode(dacCode), .busy(busy), .sampling(sampling), .done(done),
    .result(result), .minSampleQ(minSampleQ), .stcFit(stcFit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bitsOf(input int sel);
    return (sel == 0) ? 8 : (sel == 1) ? 10 : 12;
  endfunction

  task automatic runConv(input int stc, input int sel, input int code, input bit poke);
    int nb = bitsOf(sel);
    int sampleCnt = 1;
    int busyCnt = 1;
    int firstTrial = -1;
    int cyc = 0;
    @(negedge clk);
    stcIn = 8'(stc); resSel = 2'(sel); analogCode = code; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    stcIn = ~8'(stc);
    resSel = 2'((sel + 1) % 3);
    chk(busy && sampling, "R2 busy and sampling after start", int'({busy, sampling}), 3);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) startReq = 1'b1;
      if (poke && cyc == 4) startReq = 1'b0;
      if (!done) begin
        if (busy) busyCnt++;
        if (sampling) sampleCnt++;
        if (busy && !sampling && dacCode != 0 && firstTrial < 0) firstTrial = int'(dacCode);
      end
    end
    chk(done && !busy, "R7 done with busy low", int'({done, busy}), 2);
    chk(sampleCnt == stc + 2, "R3 R9 sample window length", sampleCnt, stc + 2);
    chk(busyCnt - sampleCnt == HOLD_CYC + nb, "R4 R9 hold plus conversion length",
        busyCnt - sampleCnt, HOLD_CYC + nb);
    chk(int'(result) == code, "R5 R9 result code", int'(result), code);
    chk(firstTrial == (1 << (nb - 1)), "R6 first trial code", firstTrial, 1 << (nb - 1));
    @(negedge clk);
    chk(!done, "R7 done pulse width", int'(done), 0);
    chk(int'(result) == code, "R7 result held", int'(result), code);
    if (poke) begin
      repeat (4) begin
        @(negedge clk);
        chk(!busy && !sampling, "R8 no conversion from late start", int'({busy, sampling}), 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !sampling && !done, "R1 status in reset", int'({busy, sampling, done}), 0);
    chk(result == 0 && dacCode == 0, "R1 result and trial in reset", int'(result), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !sampling && !done, "R1 idle after reset", int'({busy, sampling, done}), 0);
    chk(result == 0 && dacCode == 0, "R1 outputs idle after reset", int'(dacCode), 0);

    // R10 sizing helper sweep across both clamps
    for (int q = 0; q <= 4400; q++) begin
      int c, e;
      minSampleQ = 16'(q);
      #1;
      c = (q + 15) / 16;
      e = (c <= 2) ? 0 : ((c - 2 > 255) ? 255 : c - 2);
      chk(int'(stcFit) == e, "R10 stcFit", int'(stcFit), e);
    end
    minSampleQ = 16'd72;  #1; chk(stcFit == 8'd3, "R10 8-bit example", int'(stcFit), 3);
    minSampleQ = 16'd88;  #1; chk(stcFit == 8'd4, "R10 10-bit example", int'(stcFit), 4);
    minSampleQ = 16'd104; #1; chk(stcFit == 8'd5, "R10 12-bit example", int'(stcFit), 5);
    minSampleQ = 16'hFFFF; #1; chk(stcFit == 8'd255, "R10 upper clamp", int'(stcFit), 255);

    for (int code = 0; code < 256; code++) runConv(code % 7, 0, code, code % 16 == 5);
    for (int code = 0; code < 1024; code += 37) runConv(code % 11, 1, code, 1'b0);
    runConv(3, 1, 1023, 1'b1);
    for (int code = 0; code < 4096; code += 97) runConv(code % 5, 2, code, 1'b0);
    runConv(0, 2, 4095, 1'b1);
    runConv(2, 3, 4095, 1'b0);
    runConv(4, 3, 1234, 1'b0);
    for (int s = 0; s < 256; s++) runConv(s, 0, 8'hA5 ^ s, s % 32 == 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule